// File: doc/BRIEF.md
# Hall-Driven Six-Step Commutation Decoder

This block turns the state of three rotor position sensors and a rotation direction bit into the six gate signals of a three-phase inverter bridge. The three high-side gates are named U, V and W, and the three low-side gates are named X, Y and Z. X pairs with U, Y with V, and Z with W. Each gate is driven in one of four ways: held low, held high, following the PWM carrier from a separate carrier block, or following the inverse of that carrier.

The built-in pattern works as follows. One high side carries the PWM and the low side of the same phase carries the complementary PWM. A low side on a second phase is held on. Which phases are used depends on the sensor code and on the direction. A programmable table can replace the built-in pattern. The sensor code can come from the pins or from a software-written value. Sensor codes 000 and 111 cannot occur on a healthy motor. They raise an error flag and switch every gate off.

The gate outputs are registered on the system clock, so they change only at a clock edge and carry no decoding glitches.

Top module: `hall_commutator`

## Requirements
- R1: When the selected sensor code is 000 or 111, all six gate outputs are 0 after the next clock edge. This holds for either direction and for either table.
- R2: `hall_err` is a combinational output. It is 1 exactly when the selected sensor code is 000 or 111.
- R3: With `dir`=1 and the built-in table, each sensor code drives the gates below, where P is the carrier and Pb its inverse. Every gate not listed is 0.
  - 001: U=P, X=Pb, Y=1
  - 011: W=P, Z=Pb, Y=1
  - 010: W=P, Z=Pb, X=1
  - 110: V=P, Y=Pb, X=1
  - 100: V=P, Y=Pb, Z=1
  - 101: U=P, X=Pb, Z=1
- R4: With `dir`=0 and the built-in table, each sensor code drives the gates below. Every gate not listed is 0.
  - 101: W=P, Z=Pb, X=1
  - 100: W=P, Z=Pb, Y=1
  - 110: U=P, X=Pb, Y=1
  - 010: U=P, X=Pb, Z=1
  - 011: V=P, Y=Pb, Z=1
  - 001: V=P, Y=Pb, X=1
- R5: Every gate output reflects, one clock edge later, the inputs sampled at that edge. The carrier and its inverse are sampled in the same way.
- R6: When `hall_src_sw`=1, the code on `hall_sw` is used and `hall_pins` has no effect. When `hall_src_sw`=0, the reverse applies.
- R7: When `use_user`=1, the gates follow the 12-bit table entry at address {dir, sensor code}. Gate g (U=0, V=1, W=2, X=3, Y=4, Z=5) takes bits [2g+1:2g] of the entry. The codes are 00 for 0, 01 for 1, 10 for P and 11 for Pb.
- R8: A clock edge with `tbl_we`=1 stores `tbl_wdata` at `tbl_waddr`. The stored entry is in effect from the next edge. Every other entry is left unchanged.
- R9: During reset, all gate outputs are 0 and all table entries are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_pins | input | 3 | Synchronised sensor code from the pins |
| hall_sw | input | 3 | Sensor code written by software |
| hall_src_sw | input | 1 | 1 selects `hall_sw`, 0 selects `hall_pins` |
| dir | input | 1 | Rotation direction |
| pwm | input | 1 | PWM carrier output |
| use_user | input | 1 | 1 selects the programmable table |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 4 | Table write address {dir, code} |
| tbl_wdata | input | 12 | Table entry, two bits per gate |
| gate_hi | output | 3 | High-side gates, W U order msb to lsb: [2]=W, [1]=V, [0]=U |
| gate_lo | output | 3 | Low-side gates: [2]=Z, [1]=Y, [0]=X |
| hall_err | output | 1 | Illegal sensor code flag |

## Verification
The hardest situation to reach is a programmable table entry that is read back under a specific direction, sensor code and carrier level. A second hard case is showing that a write to one address leaves its neighbours untouched. The stimulus fills all sixteen entries with distinct values computed from their addresses. It then sweeps direction, code and carrier level in both table modes. Finally it rewrites a single entry and re-reads the adjacent address. The illegal codes are also driven through the software source while the pins hold a legal code, so that the selected source alone decides the outcome.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int PHASES = 3;
  localparam int GATES  = 2 * PHASES;
  localparam int CODE_W = 2;
  localparam int WORD_W = GATES * CODE_W;
  localparam int HALL_W = 3;
  localparam int ADDR_W = HALL_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [CODE_W-1:0] {
    GC_OFF  = 2'b00,
    GC_ON   = 2'b01,
    GC_PWM  = 2'b10,
    GC_PWMN = 2'b11
  } gcode_t;
endpackage

// File: rtl/hc_default_map.sv
module hc_default_map
  import hc_pkg::*;
(
  input  logic              dir,
  input  logic [HALL_W-1:0] hall,
  output logic [WORD_W-1:0] codes
);
  logic [2:0] hp_idx;
  logic [2:0] st_idx;
  logic       legal;

  always_comb begin
    legal  = 1'b1;
    hp_idx = 3'd0;
    st_idx = 3'd0;
    unique case ({dir, hall})
      4'b1_001: begin hp_idx = 3'd0; st_idx = 3'd4; end
      4'b1_011: begin hp_idx = 3'd2; st_idx = 3'd4; end
      4'b1_010: begin hp_idx = 3'd2; st_idx = 3'd3; end
      4'b1_110: begin hp_idx = 3'd1; st_idx = 3'd3; end
      4'b1_100: begin hp_idx = 3'd1; st_idx = 3'd5; end
      4'b1_101: begin hp_idx = 3'd0; st_idx = 3'd5; end
      4'b0_101: begin hp_idx = 3'd2; st_idx = 3'd3; end
      4'b0_100: begin hp_idx = 3'd2; st_idx = 3'd4; end
      4'b0_110: begin hp_idx = 3'd0; st_idx = 3'd4; end
      4'b0_010: begin hp_idx = 3'd0; st_idx = 3'd5; end
      4'b0_011: begin hp_idx = 3'd1; st_idx = 3'd5; end
      4'b0_001: begin hp_idx = 3'd1; st_idx = 3'd3; end
      default:  legal = 1'b0;
    endcase
  end

  always_comb begin
    codes = '0;
    for (int g = 0; g < GATES; g++) begin
      if (legal) begin
        if (3'(g) == hp_idx)                codes[g*CODE_W +: CODE_W] = GC_PWM;
        else if (3'(g) == hp_idx + 3'(PHASES)) codes[g*CODE_W +: CODE_W] = GC_PWMN;
        else if (3'(g) == st_idx)           codes[g*CODE_W +: CODE_W] = GC_ON;
      end
    end
  end
endmodule

// File: rtl/hc_user_table.sv
module hc_user_table
  import hc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
    end
    if (we) mem_d[waddr] = wdata;
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       mem_q[e] <= '0;
        else if (we && waddr == ADDR_W'(e)) mem_q[e] <= mem_d[e];
      end
    end
  endgenerate

  assign rdata = mem_q[raddr];

  // R8: a written entry reads back as written
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/hc_gate_drive.sv
module hc_gate_drive
  import hc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] codes,
  input  logic              pwm,
  input  logic              kill,
  output logic [GATES-1:0]  gates
);
  logic [GATES-1:0] gates_d;
  logic [GATES-1:0] gates_q;

  generate
    for (genvar g = 0; g < GATES; g++) begin : g_gate
      always_comb begin
        if (kill) begin
          gates_d[g] = 1'b0;
        end else begin
          unique case (gcode_t'(codes[g*CODE_W +: CODE_W]))
            GC_OFF:  gates_d[g] = 1'b0;
            GC_ON:   gates_d[g] = 1'b1;
            GC_PWM:  gates_d[g] = pwm;
            GC_PWMN: gates_d[g] = ~pwm;
            default: gates_d[g] = 1'b0;
          endcase
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gates_q <= '0;
    else        gates_q <= gates_d;
  end

  assign gates = gates_q;

  // R1: an illegal code switches every gate off at the next edge
  a_r1_kill_off: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> gates == '0);
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  hall_pins,
  input  logic [2:0]  hall_sw,
  input  logic        hall_src_sw,
  input  logic        dir,
  input  logic        pwm,
  input  logic        use_user,
  input  logic        tbl_we,
  input  logic [3:0]  tbl_waddr,
  input  logic [11:0] tbl_wdata,
  output logic [2:0]  gate_hi,
  output logic [2:0]  gate_lo,
  output logic        hall_err
);
  logic [HALL_W-1:0] hall_sel;
  logic [WORD_W-1:0] def_codes;
  logic [WORD_W-1:0] usr_codes;
  logic [WORD_W-1:0] act_codes;
  logic [GATES-1:0]  gates;

  assign hall_sel  = hall_src_sw ? hall_sw : hall_pins;
  assign hall_err  = (hall_sel == '0) || (hall_sel == '1);
  assign act_codes = use_user ? usr_codes : def_codes;

  hc_default_map u_def (
    .dir   (dir),
    .hall  (hall_sel),
    .codes (def_codes)
  );

  hc_user_table u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr ({dir, hall_sel}),
    .rdata (usr_codes)
  );

  hc_gate_drive u_drv (
    .clk   (clk),
    .rst_n (rst_n),
    .codes (act_codes),
    .pwm   (pwm),
    .kill  (hall_err),
    .gates (gates)
  );

  assign gate_hi = gates[PHASES-1:0];
  assign gate_lo = gates[GATES-1:PHASES];

  // R3/R4: built-in table never turns both switches of one leg on
  a_r3_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(use_user) |-> (gate_hi & gate_lo) == 3'b000);

  // R4: built-in table drives at most one high side
  a_r4_one_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(use_user) |-> $countones(gate_hi) <= 1);
endmodule

// File: tb/hall_commutator_tb.sv
module hall_commutator_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  hall_pins, hall_sw;
  logic        hall_src_sw, dir, pwm, use_user, tbl_we;
  logic [3:0]  tbl_waddr;
  logic [11:0] tbl_wdata;
  logic [2:0]  gate_hi, gate_lo;
  logic        hall_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hall_commutator u_dut (
    .clk(clk), .rst_n(rst_n), .hall_pins(hall_pins), .hall_sw(hall_sw),
    .hall_src_sw(hall_src_sw), .dir(dir), .pwm(pwm), .use_user(use_user),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .hall_err(hall_err)
  );

  function automatic logic [5:0] exp_def(input logic d, input logic [2:0] h, input logic p);
    int hp, st;
    logic [5:0] r;
    hp = -1; st = -1; r = '0;
    if (d) case (h)
      3'b001: begin hp = 0; st = 4; end
      3'b011: begin hp = 2; st = 4; end
      3'b010: begin hp = 2; st = 3; end
      3'b110: begin hp = 1; st = 3; end
      3'b100: begin hp = 1; st = 5; end
      3'b101: begin hp = 0; st = 5; end
      default: ;
    endcase
    else case (h)
      3'b101: begin hp = 2; st = 3; end
      3'b100: begin hp = 2; st = 4; end
      3'b110: begin hp = 0; st = 4; end
      3'b010: begin hp = 0; st = 5; end
      3'b011: begin hp = 1; st = 5; end
      3'b001: begin hp = 1; st = 3; end
      default: ;
    endcase
    if (hp >= 0) begin
      r[hp] = p; r[hp+3] = ~p; r[st] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [11:0] user_word(input int a, input int salt);
    return 12'((a * 12'h2D7 + salt * 12'h1B5) ^ 12'h96C);
  endfunction

  function automatic logic [5:0] exp_usr(input logic [11:0] w, input logic [2:0] h, input logic p);
    logic [5:0] r;
    for (int g = 0; g < 6; g++) begin
      case (w[2*g +: 2])
        2'b00: r[g] = 1'b0;
        2'b01: r[g] = 1'b1;
        2'b10: r[g] = p;
        default: r[g] = ~p;
      endcase
    end
    if (h == 3'b000 || h == 3'b111) r = '0;
    return r;
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] h, input logic d, input logic p);
    @(negedge clk);
    if (hall_src_sw) hall_sw = h; else hall_pins = h;
    dir = d; pwm = p;
    @(posedge clk); #1;
  endtask

  logic [11:0] shadow [16];

  initial begin
    rst_n = 1'b0; hall_pins = 3'b001; hall_sw = 3'b000; hall_src_sw = 1'b0;
    dir = 1'b1; pwm = 1'b1; use_user = 1'b0; tbl_we = 1'b0;
    tbl_waddr = '0; tbl_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", {gate_lo, gate_hi}, 6'b0);
    @(negedge clk); rst_n = 1'b1;

    // R9: table cleared by reset -> user mode drives nothing
    use_user = 1'b1;
    apply(3'b001, 1'b1, 1'b1);
    check("R9 table cleared", {gate_lo, gate_hi}, 6'b0);
    use_user = 1'b0;

    // R2 hall_err for every code, both sources
    for (int s = 0; s < 2; s++) begin
      for (int h = 0; h < 8; h++) begin
        @(negedge clk);
        hall_src_sw = s[0];
        hall_pins = s[0] ? 3'b010 : 3'(h);
        hall_sw   = s[0] ? 3'(h) : 3'b111;
        #1;
        check("R2 hall_err", {5'b0, hall_err}, {5'b0, (h == 0 || h == 7)});
      end
    end

    // R3 R4 R1 R5 built-in table, pins source
    hall_src_sw = 1'b0;
    for (int d = 0; d < 2; d++)
      for (int h = 0; h < 8; h++)
        for (int p = 0; p < 2; p++) begin
          apply(3'(h), d[0], p[0]);
          check(d ? "R3 dir1 map" : "R4 dir0 map", {gate_lo, gate_hi},
                exp_def(d[0], 3'(h), p[0]));
        end

    // R5 latency: change pwm, output holds until the next edge
    apply(3'b001, 1'b1, 1'b1);
    @(negedge clk); pwm = 1'b0; #1;
    check("R5 holds before edge", {gate_lo, gate_hi}, exp_def(1'b1, 3'b001, 1'b1));
    @(posedge clk); #1;
    check("R5 updates after edge", {gate_lo, gate_hi}, exp_def(1'b1, 3'b001, 1'b0));

    // R6 software source; pins hold another legal code
    hall_src_sw = 1'b1; hall_pins = 3'b110;
    for (int h = 0; h < 8; h++) begin
      apply(3'(h), 1'b0, 1'b1);
      check("R6 sw source", {gate_lo, gate_hi}, exp_def(1'b0, 3'(h), 1'b1));
    end
    // R6 illegal sw code wins over legal pins (R1)
    @(negedge clk); hall_sw = 3'b111; hall_pins = 3'b101; @(posedge clk); #1;
    check("R6 R1 sw illegal", {gate_lo, gate_hi}, 6'b0);
    hall_src_sw = 1'b0;

    // R8 fill table
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_waddr = 4'(a); tbl_wdata = user_word(a, 0);
      shadow[a] = user_word(a, 0);
    end
    @(negedge clk); tbl_we = 1'b0;

    // R7 user table sweep
    use_user = 1'b1;
    for (int d = 0; d < 2; d++)
      for (int h = 0; h < 8; h++)
        for (int p = 0; p < 2; p++) begin
          apply(3'(h), d[0], p[0]);
          check((h == 0 || h == 7) ? "R1 user illegal" : "R7 user map",
                {gate_lo, gate_hi}, exp_usr(shadow[{d[0], 3'(h)}], 3'(h), p[0]));
        end

    // R8 rewrite one entry, check it and its neighbour
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 4'b1_011; tbl_wdata = user_word(11, 5);
    shadow[11] = user_word(11, 5);
    @(negedge clk); tbl_we = 1'b0;
    apply(3'b011, 1'b1, 1'b0);
    check("R8 rewrite", {gate_lo, gate_hi}, exp_usr(shadow[11], 3'b011, 1'b0));
    apply(3'b010, 1'b1, 1'b0);
    check("R8 neighbour kept", {gate_lo, gate_hi}, exp_usr(shadow[10], 3'b010, 1'b0));
    apply(3'b100, 1'b1, 1'b1);
    check("R8 neighbour kept", {gate_lo, gate_hi}, exp_usr(shadow[12], 3'b100, 1'b1));

    // R7 back to built-in table
    use_user = 1'b0;
    apply(3'b110, 1'b1, 1'b1);
    check("R7 built-in restored", {gate_lo, gate_hi}, exp_def(1'b1, 3'b110, 1'b1));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule